// File: doc/BRIEF.md
# Coprocessor-Busy Branch Resolver

This block decides branches whose condition is the live busy state of an attached vector coprocessor. Each cycle it may take one instruction word, the address of that instruction, the coprocessor busy flag and the coprocessor-usable status bit. One clock later it reports four things. It gives a taken flag and the branch target. It gives a flag that tells the pipeline to cancel the delay-slot instruction. It gives two exception flags: coprocessor unusable and reserved instruction.

There are four branch variants. Two of them branch when the coprocessor is idle and two branch when it is busy. One variant of each pair is a "likely" form: when that form is not taken, the following instruction is cancelled. Fetch, delay-slot execution and exception handling are left to the surrounding pipeline.

Top module: `cpbr_resolve`

## Requirements
- R1: `res_valid` is 1 in the cycle after a cycle with `req_valid` = 1 and is 0 after a cycle with `req_valid` = 0.
- R2: A word is a branch only when bits 25..21 equal 5'h08. Any other value in that field gives `res_taken`, `res_nullify` and `res_reserved` equal to 0.
- R3: Selector bits 20..16 = 0 branch when `cop_busy` = 0. Selector value 1 branches when `cop_busy` = 1. Taken is reported on `res_taken`.
- R4: Selector value 2 uses the condition of value 0 and selector value 3 uses the condition of value 1. When either of them is not taken, `res_nullify` = 1.
- R5: Selector values 0 and 1 never raise `res_nullify`.
- R6: `res_target` = `req_addr` + 4 + (sign-extended bits 15..0 shifted left by 2), modulo 2^ADDR_W. It is reported on every valid result.
- R7: When `cop_usable` = 0, `res_unusable` = 1 for any valid word. In that case `res_taken`, `res_nullify` and `res_reserved` are 0.
- R8: When the branch field matches and the selector is 4 or more, with `cop_usable` = 1, `res_reserved` = 1 and `res_taken` = `res_nullify` = 0.
- R9: All four flags are 0 whenever `res_valid` is 0.
- R10: While `rst_n` is low at a clock edge, every output, including `res_target`, is cleared to 0.
- R11: `cop_busy` is sampled only in the cycle where `req_valid` = 1. A change of `cop_busy` after that edge does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Instruction presented this cycle |
| req_instr | input | 32 | Instruction word |
| req_addr | input | ADDR_W | Address of the instruction |
| cop_busy | input | 1 | Coprocessor busy status |
| cop_usable | input | 1 | Coprocessor-usable status bit |
| res_valid | output | 1 | Result strobe, one cycle after `req_valid` |
| res_taken | output | 1 | Branch taken |
| res_target | output | ADDR_W | Branch target address |
| res_nullify | output | 1 | Cancel the delay-slot instruction |
| res_unusable | output | 1 | Coprocessor-unusable exception |
| res_reserved | output | 1 | Reserved-instruction exception |

## Verification
The assertions assume that `req_valid` is low during reset. They also assume that `cop_usable`, `cop_busy` and the instruction word are stable at the sampling edge of a valid request, because they compare the flags with the values those inputs held at the previous edge.

The stimulus drives every input on the falling edge, so each input is settled by the following rising edge. It holds `req_valid` low until reset has been released. The branch field is biased strongly towards 5'h08 so that all selector values, both busy states and both usable states occur often. `cop_busy` is flipped only after the sampling edge, which checks that it has no late influence.

// File: rtl/cpbr_pkg.sv
`timescale 1ns/1ps
// Shared field positions and types for the coprocessor-busy branch resolver.
// Assumes a 32-bit instruction word with the branch field at bits 25..21.
package cpbr_pkg;
    localparam int INSTR_W  = 32;
    localparam int OPF_LSB  = 21;
    localparam int OPF_W    = 5;
    localparam int SEL_LSB  = 16;
    localparam int SEL_W    = 5;
    localparam int IMM_W    = 16;
    localparam logic [OPF_W-1:0] OPF_BRANCH = 5'h08;
    localparam int SEL_LAST = 3;

    // Static classification of one instruction word.
    typedef struct packed {
        logic is_branch;   // branch field matches
        logic reserved;    // branch field matches, selector out of range
        logic want_busy;   // branch condition is coprocessor busy
        logic likely;      // not-taken cancels the delay slot
    } brclass_t;

    // Resolved decision flags.
    typedef struct packed {
        logic taken;
        logic nullify;
        logic unusable;
        logic reserved;
    } brflags_t;
endpackage

// File: rtl/cpbr_decode.sv
`timescale 1ns/1ps
// Instruction field decoder.
// Classifies a word as branch, reserved or other, and extracts the immediate.
// Assumes: purely combinational; no knowledge of coprocessor state.
module cpbr_decode
    import cpbr_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output brclass_t           cls,
    output logic [IMM_W-1:0]   imm
);
    logic [OPF_W-1:0] opf;
    logic [SEL_W-1:0] sel;

    // Split the word into its fields.
    always_comb begin
        opf = instr[OPF_LSB +: OPF_W];
        sel = instr[SEL_LSB +: SEL_W];
        imm = instr[IMM_W-1:0];
    end

    // Classify the branch variant from the selector.
    always_comb begin
        cls.is_branch = (opf == OPF_BRANCH);
        cls.reserved  = cls.is_branch && (sel > SEL_W'(SEL_LAST));
        cls.want_busy = sel[0];
        cls.likely    = sel[1];
    end
endmodule

// File: rtl/cpbr_target.sv
`timescale 1ns/1ps
// Branch target adder: address + 4 + sign-extended word offset.
// Assumes ADDR_W >= 3; a narrower address truncates the offset.
module cpbr_target
    import cpbr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] target
);
    localparam int OFS_W = IMM_W + 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic [OFS_W-1:0]  ofs_raw;
    logic [ADDR_W-1:0] ofs;

    // Scale the immediate to a byte offset.
    always_comb ofs_raw = {imm, 2'b00};

    generate
        if (ADDR_W > OFS_W) begin : g_extend
            // Sign-extend the byte offset to the address width.
            always_comb ofs = {{(ADDR_W-OFS_W){imm[IMM_W-1]}}, ofs_raw};
        end else begin : g_trunc
            // Address narrower than offset: keep the low bits.
            always_comb ofs = ofs_raw[ADDR_W-1:0];
        end
    endgenerate

    // Add the offset to the address of the following instruction.
    always_comb target = addr + STEP + ofs;
endmodule

// File: rtl/cpbr_decide.sv
`timescale 1ns/1ps
// Branch decision logic.
// Combines classification, busy and usable status into result flags.
// Assumes: the caller qualifies the flags with its valid strobe.
module cpbr_decide
    import cpbr_pkg::*;
(
    input  brclass_t cls,
    input  logic     busy,
    input  logic     usable,
    output brflags_t flags
);
    logic legal;
    logic cond;

    // Determine whether a legal branch is present and whether its condition holds.
    always_comb begin
        legal = usable && cls.is_branch && !cls.reserved;
        cond  = (busy == cls.want_busy);
    end

    // Produce the taken, nullify and exception flags; unusable suppresses the rest.
    always_comb begin
        flags.unusable = !usable;
        flags.reserved = usable && cls.reserved;
        flags.taken    = legal && cond;
        flags.nullify  = legal && cls.likely && !cond;
    end
endmodule

// File: rtl/cpbr_resolve.sv
`timescale 1ns/1ps
// Coprocessor-busy branch resolver, top level.
// Decodes a word, evaluates the busy condition in the request cycle and
// registers the decision; results appear one cycle after req_valid.
// Assumes: synchronous active-low reset; req_valid low during reset.
module cpbr_resolve
    import cpbr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_instr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cop_busy,
    input  logic              cop_usable,
    output logic              res_valid,
    output logic              res_taken,
    output logic [ADDR_W-1:0] res_target,
    output logic              res_nullify,
    output logic              res_unusable,
    output logic              res_reserved
);
    brclass_t          cls;
    logic [IMM_W-1:0]  imm;
    logic [ADDR_W-1:0] tgt_next;
    brflags_t          flags_next;
    brflags_t          flags_q;

    cpbr_decode u_decode (
        .instr (req_instr),
        .cls   (cls),
        .imm   (imm)
    );

    cpbr_target #(.ADDR_W(ADDR_W)) u_target (
        .addr   (req_addr),
        .imm    (imm),
        .target (tgt_next)
    );

    cpbr_decide u_decide (
        .cls    (cls),
        .busy   (cop_busy),
        .usable (cop_usable),
        .flags  (flags_next)
    );

    // Register the strobe and the flags; flags are cleared when no request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            flags_q   <= '0;
        end else begin
            res_valid <= req_valid;
            flags_q   <= req_valid ? flags_next : '0;
        end
    end

    // Register the target on each request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_target <= '0;
        end else if (req_valid) begin
            res_target <= tgt_next;
        end
    end

    // Drive the flag outputs from the registered flags.
    always_comb begin
        res_taken    = flags_q.taken;
        res_nullify  = flags_q.nullify;
        res_unusable = flags_q.unusable;
        res_reserved = flags_q.reserved;
    end
endmodule

// File: rtl/cpbr_resolve_chk.sv
`timescale 1ns/1ps
// Property checker for cpbr_resolve, attached through bind.
// Assumes inputs are stable at the sampling edge of a valid request.
module cpbr_resolve_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [31:0]       req_instr,
    input logic [ADDR_W-1:0] req_addr,
    input logic              cop_busy,
    input logic              cop_usable,
    input logic              res_valid,
    input logic              res_taken,
    input logic [ADDR_W-1:0] res_target,
    input logic              res_nullify,
    input logic              res_unusable,
    input logic              res_reserved
);
    logic br_sel0;
    logic br_sel1;
    logic br_short;

    // Recognise the request patterns that the properties refer to.
    always_comb begin
        br_sel0  = req_instr[25:21] == 5'h08 && req_instr[20:16] == 5'd0;
        br_sel1  = req_instr[25:21] == 5'h08 && req_instr[20:16] == 5'd1;
        br_short = br_sel0 || br_sel1;
    end

    assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    assert_strobe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    assert_idle_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cop_usable && br_sel0 && !cop_busy) |=> res_taken);
    assert_busy_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cop_usable && br_sel1 && cop_busy) |=> res_taken);
    assert_no_nullify_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && br_short) |=> !res_nullify);
    assert_unusable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cop_usable) |=> (res_unusable && !res_taken && !res_nullify && !res_reserved));
    assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_reserved |-> (!res_taken && !res_nullify));
    assert_flags_need_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_taken || res_nullify || res_unusable || res_reserved));
    assert_taken_xor_nullify_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({res_taken, res_nullify}) <= 1);
endmodule

bind cpbr_resolve cpbr_resolve_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_instr    (req_instr),
    .req_addr     (req_addr),
    .cop_busy     (cop_busy),
    .cop_usable   (cop_usable),
    .res_valid    (res_valid),
    .res_taken    (res_taken),
    .res_target   (res_target),
    .res_nullify  (res_nullify),
    .res_unusable (res_unusable),
    .res_reserved (res_reserved)
);

// File: tb/cpbr_resolve_test.sv
`timescale 1ns/1ps
// Self-checking bench for cpbr_resolve: directed corners plus seeded random words.
module cpbr_resolve_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_instr = '0;
    logic [AW-1:0] req_addr = '0;
    logic          cop_busy = 1'b0;
    logic          cop_usable = 1'b0;
    logic          res_valid, res_taken, res_nullify, res_unusable, res_reserved;
    logic [AW-1:0] res_target;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cpbr_resolve #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_instr(req_instr),
        .req_addr(req_addr), .cop_busy(cop_busy), .cop_usable(cop_usable),
        .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
        .res_nullify(res_nullify), .res_unusable(res_unusable), .res_reserved(res_reserved)
    );

    task automatic chk(input string req, input string what, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_target(input logic [31:0] w, input logic [AW-1:0] a);
        return a + 32'd4 + {{14{w[15]}}, w[15:0], 2'b00};
    endfunction

    // Expected flags {taken, nullify, unusable, reserved} from the requirements.
    function automatic logic [3:0] exp_flags(input logic [31:0] w, input logic busy,
                                             input logic usable);
        logic br, cond;
        if (!usable) return 4'b0010;                     // R7
        br = (w[25:21] == 5'h08);                        // R2
        if (!br) return 4'b0000;
        if (w[20:16] > 5'd3) return 4'b0001;             // R8
        cond = (busy == w[16]);                          // R3
        if (cond) return 4'b1000;
        return {1'b0, w[17], 2'b00};                     // R4, R5
    endfunction

    task automatic send(input logic [31:0] w, input logic [AW-1:0] a, input logic busy,
                        input logic usable);
        logic [3:0] ef;
        ef = exp_flags(w, busy, usable);
        @(negedge clk);
        req_valid = 1'b1; req_instr = w; req_addr = a; cop_busy = busy; cop_usable = usable;
        @(posedge clk);
        #0.5;
        cop_busy = ~busy;            // R11: late change must not matter
        req_valid = 1'b0; req_instr = $urandom; req_addr = $urandom;
        #1;
        chk("R1", "valid", AW'(res_valid), AW'(1));
        chk("R3,R11", "taken", AW'(res_taken), AW'(ef[3]));
        chk((w[17] ? "R4" : "R5"), "nullify", AW'(res_nullify), AW'(ef[2]));
        chk("R7", "unusable", AW'(res_unusable), AW'(ef[1]));
        chk("R8,R2", "reserved", AW'(res_reserved), AW'(ef[0]));
        chk("R6", "target", res_target, exp_target(w, a));
    endtask

    task automatic idle_check();
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1.5;
        chk("R1", "idle valid", AW'(res_valid), AW'(0));
        chk("R9", "idle flags", AW'({res_taken, res_nullify, res_unusable, res_reserved}), AW'(0));
    endtask

    function automatic logic [31:0] mk(input logic [4:0] opf, input logic [4:0] sel,
                                       input logic [15:0] imm);
        return {6'h12, opf, sel, imm};
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R10: reset clears every output.
        chk("R10", "reset valid", AW'(res_valid), AW'(0));
        chk("R10", "reset flags", AW'({res_taken, res_nullify, res_unusable, res_reserved}), AW'(0));
        chk("R10", "reset target", res_target, AW'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // Every selector in the legal range, with both busy states.
        for (int s = 0; s < 4; s++) begin
            send(mk(5'h08, 5'(s), 16'h0010), 32'h0000_1000, 1'b0, 1'b1);
            send(mk(5'h08, 5'(s), 16'h0010), 32'h0000_1000, 1'b1, 1'b1);
        end
        // R2: field mismatch is not a branch.
        send(mk(5'h09, 5'd0, 16'h0004), 32'h0000_2000, 1'b0, 1'b1);
        // R8: reserved selectors.
        send(mk(5'h08, 5'd4, 16'h0001), 32'h0000_3000, 1'b0, 1'b1);
        send(mk(5'h08, 5'd31, 16'h0001), 32'h0000_3000, 1'b1, 1'b1);
        // R7: unusable coprocessor, for a branch and a reserved selector.
        send(mk(5'h08, 5'd1, 16'h0001), 32'h0000_4000, 1'b1, 1'b0);
        send(mk(5'h08, 5'd6, 16'h0001), 32'h0000_4000, 1'b1, 1'b0);
        // R6: most negative offset and address wrap.
        send(mk(5'h08, 5'd0, 16'h8000), 32'h0000_0100, 1'b0, 1'b1);
        send(mk(5'h08, 5'd0, 16'h0000), 32'hFFFF_FFFC, 1'b0, 1'b1);
        send(mk(5'h08, 5'd2, 16'hFFFF), 32'h0000_0000, 1'b1, 1'b1);
        // R9: no request, no flags; back-to-back requests after.
        idle_check();
        idle_check();

        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            w = $urandom;
            if (($urandom % 4) != 0) w[25:21] = 5'h08;
            if (($urandom % 3) != 0) w[20:16] = 5'($urandom % 4);
            send(w, $urandom, 1'($urandom), (($urandom % 5) != 0));
            if (($urandom % 8) == 0) idle_check();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule